// File: doc/BRIEF.md
# Multiplexed-Bus Register and Interrupt Unit

This block is a slave register interface for a microcontroller bus that carries both address and data on one 8-bit path. An address latch enable, active-low read and write strobes and a chip select control each access. All bus pins are synchronised to the system clock. The address is taken when the latch enable falls. A write takes effect when its strobe rises. A read drives data while chip select and read are both low. The side effect of a read, where a register has one, takes place when the read strobe rises.

The unit holds three semaphore registers. Two processors use them to pass bytes to each other. Each semaphore has a change flag in the status register. The status register mixes live inputs with latched event flags. An interrupt-enable register selects which status bits pull the active-low interrupt output. Only six address bits are decoded, so every address aliases every 64 bytes. All addresses that are not dedicated map to a plain byte-wide scratch store, which stands in for the rest of the device's registers.

Dedicated addresses, taken from the low six bits:

| Address | Register |
|---|---|
| 01H | semaphore 1 |
| 02H | semaphore 2 |
| 03H | semaphore 3 |
| 04H | status |
| 05H | interrupt enable |
| 06H | end-of-subcode-read |

Status bit positions are as follows:

| Bit | Meaning |
|---|---|
| 7 | semaphore 1 changed |
| 6 | semaphore 2 changed |
| 5 | semaphore 3 changed |
| 4 | PLL lock |
| 3 | header valid |
| 2 | motor overflow |
| 1 | FIFO overflow |
| 0 | reserved |

Top module: `mbus_regif`

## Requirements
- R1: A byte written to a non-dedicated address is returned by a later read of that address.
- R2: Only address bits 5:0 are decoded. An access to address A+40H acts exactly like an access to A. This holds for both the scratch store and the dedicated registers.
- R3: A write or read strobe made while chip select is high has no effect. Stored data is not changed, no flag is set or cleared, and the bus output enable stays off.
- R4: Writing semaphore 1, 2 or 3 (01H/02H/03H) sets status bit 7, 6 or 5 respectively. Reading that semaphore clears the bit and leaves the other two unchanged.
- R5: Status bit 4 follows the lock input and bit 2 follows the motor-overflow input, with no latching.
- R6: Status bit 3 sets on a header event and clears on a read of 06H. A header event in the same cycle as that clear leaves the bit set. A read of 06H returns 00H.
- R7: Status bit 1 latches a FIFO-overflow event and stays set until the status register (04H) is read. An event in the same cycle as that clear wins. Status bit 0 always reads 0.
- R8: The interrupt-enable register (05H) reads back as written. The interrupt output is low when any bit is set in both the status and enable registers, and high otherwise.
- R9: Semaphore 3 returns bit 1 as 0. All other semaphore bits return the last value written.
- R10: The bus output enable is on only while chip select and read are both low. Reset leaves the output enable off and the interrupt output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_ad_i | input | 8 | multiplexed address/data from the bus |
| ale_i | input | 1 | address latch enable; the address is taken on its fall |
| rd_n_i | input | 1 | read strobe, active low |
| wr_n_i | input | 1 | write strobe, active low |
| cs_n_i | input | 1 | chip select, active low; gates both strobes |
| bus_ad_o | output | 8 | read data toward the bus |
| bus_oe_o | output | 1 | bus driver enable; off models high impedance |
| lock_i | input | 1 | live PLL lock indication |
| hdr_evt_i | input | 1 | one-cycle new-header event |
| motor_ovf_i | input | 1 | live motor overflow indication |
| fifo_ovf_i | input | 1 | one-cycle FIFO overflow event |
| irq_n_o | output | 1 | interrupt, active low |

## Verification
The bench builds the block with its defaults: 8-bit data, two synchroniser stages and the six-bit decode. Two stages give a fixed, known delay from a strobe edge to its effect. The bench uses that delay to place a header event exactly in the cycle of the clear-on-read, so the event-wins rule can be tested at the pins. The six-bit decode lets accesses above 3FH be aimed at both the scratch store and a semaphore, which shows the aliasing. A behavioural model of the flags and registers predicts the interrupt output, and the bench compares the two on every settled clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned ADDR_BITS = 6;
  typedef logic [ADDR_BITS-1:0] reg_addr_t;

  localparam reg_addr_t A_SEMA1  = 6'h01;
  localparam reg_addr_t A_STAT   = 6'h04;
  localparam reg_addr_t A_IRQEN  = 6'h05;
  localparam reg_addr_t A_SUBEND = 6'h06;
  localparam int unsigned N_SEMA = 3;

  localparam int unsigned B_LOCK  = 4;
  localparam int unsigned B_HDR   = 3;
  localparam int unsigned B_MOTOR = 2;
  localparam int unsigned B_FIFO  = 1;

  function automatic reg_addr_t sema_addr(int unsigned idx);
    return A_SEMA1 + reg_addr_t'(idx);
  endfunction

  function automatic int unsigned sema_bit(int unsigned idx);
    return 7 - idx;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mbus_front.sv
module mbus_front
  import mbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_ad_i,
  input  logic          ale_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          cs_n_i,
  output reg_addr_t     addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wr_stb_o,
  output logic          rd_stb_o,
  output logic          rd_act_o
);
  logic [DW-1:0] bus_s;
  logic [3:0]    ctl_s;
  logic          ale_s, rd_s, wr_s, cs_s;
  logic          ale_p, rd_p, wr_p;
  reg_addr_t     addr_q;

  mbus_sync #(.W(DW), .STAGES(STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d_i(bus_ad_i), .q_o(bus_s)
  );

  mbus_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b0111)) u_ctl_sync (
    .clk(clk), .rst(rst), .d_i({ale_i, rd_n_i, wr_n_i, cs_n_i}), .q_o(ctl_s)
  );

  assign {ale_s, rd_s, wr_s, cs_s} = ctl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_p  <= 1'b0;
      rd_p   <= 1'b1;
      wr_p   <= 1'b1;
      addr_q <= '0;
    end else begin
      ale_p <= ale_s;
      rd_p  <= rd_s;
      wr_p  <= wr_s;
      if (ale_p && !ale_s) addr_q <= bus_s[ADDR_BITS-1:0];
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = bus_s;
  assign wr_stb_o = wr_s && !wr_p && !cs_s;
  assign rd_stb_o = rd_s && !rd_p && !cs_s;
  assign rd_act_o = !cs_s && !rd_s;
endmodule

// File: rtl/mbus_flags.sv
module mbus_flags
  import mbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SEMA-1:0] sema_wr_i,
  input  logic [N_SEMA-1:0] sema_rd_i,
  input  logic              stat_rd_i,
  input  logic              subend_rd_i,
  input  logic              lock_i,
  input  logic              hdr_evt_i,
  input  logic              motor_ovf_i,
  input  logic              fifo_ovf_i,
  input  logic [DW-1:0]     irq_en_i,
  output logic [DW-1:0]     status_o,
  output logic              irq_n_o
);
  logic [N_SEMA-1:0] sema_f;
  logic              hdr_f, fifo_f, irq_n_q;

  for (genvar i = 0; i < N_SEMA; i++) begin : g_semf
    always_ff @(posedge clk) begin
      if (rst)               sema_f[i] <= 1'b0;
      else if (sema_wr_i[i]) sema_f[i] <= 1'b1;
      else if (sema_rd_i[i]) sema_f[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_f   <= 1'b0;
      fifo_f  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      hdr_f   <= hdr_evt_i  || (hdr_f  && !subend_rd_i);
      fifo_f  <= fifo_ovf_i || (fifo_f && !stat_rd_i);
      irq_n_q <= ~|(status_o & irq_en_i);
    end
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < N_SEMA; i++) status_o[sema_bit(i)] = sema_f[i];
    status_o[B_LOCK]  = lock_i;
    status_o[B_HDR]   = hdr_f;
    status_o[B_MOTOR] = motor_ovf_i;
    status_o[B_FIFO]  = fifo_f;
  end

  assign irq_n_o = irq_n_q;

  AST_HDR_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    hdr_evt_i |=> status_o[B_HDR]); // R6
  AST_FIFO_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (status_o[B_FIFO] && !stat_rd_i) |=> status_o[B_FIFO]); // R7
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_ad_i,
  input  logic          ale_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          cs_n_i,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_oe_o,
  input  logic          lock_i,
  input  logic          hdr_evt_i,
  input  logic          motor_ovf_i,
  input  logic          fifo_ovf_i,
  output logic          irq_n_o
);
  localparam int unsigned NREG = 1 << ADDR_BITS;

  reg_addr_t         addr;
  logic [DW-1:0]     wdata, status, irq_en_q, mem_q, rsel, rdata_q;
  logic              wr_stb, rd_stb, rd_act, oe_q;
  logic [N_SEMA-1:0] sema_wr, sema_rd;
  logic [DW-1:0]     sema_q [N_SEMA];
  logic [DW-1:0]     mem [NREG];

  mbus_front #(.DW(DW), .STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .bus_ad_i(bus_ad_i), .ale_i(ale_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .cs_n_i(cs_n_i),
    .addr_o(addr), .wdata_o(wdata), .wr_stb_o(wr_stb),
    .rd_stb_o(rd_stb), .rd_act_o(rd_act)
  );

  for (genvar i = 0; i < N_SEMA; i++) begin : g_sema
    localparam logic [DW-1:0] KEEP = (i == 2) ? ~DW'(2) : {DW{1'b1}};
    assign sema_wr[i] = wr_stb && (addr == sema_addr(i));
    assign sema_rd[i] = rd_stb && (addr == sema_addr(i));
    always_ff @(posedge clk) begin
      if (rst)             sema_q[i] <= '0;
      else if (sema_wr[i]) sema_q[i] <= wdata & KEEP;
    end
  end

  mbus_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .sema_wr_i(sema_wr), .sema_rd_i(sema_rd),
    .stat_rd_i(rd_stb && addr == A_STAT),
    .subend_rd_i(rd_stb && addr == A_SUBEND),
    .lock_i(lock_i), .hdr_evt_i(hdr_evt_i), .motor_ovf_i(motor_ovf_i),
    .fifo_ovf_i(fifo_ovf_i), .irq_en_i(irq_en_q),
    .status_o(status), .irq_n_o(irq_n_o)
  );

  always_ff @(posedge clk) begin
    if (wr_stb) mem[addr] <= wdata;
    mem_q <= mem[addr];
  end

  always_comb begin
    rsel = mem_q;
    for (int i = 0; i < N_SEMA; i++)
      if (addr == sema_addr(i)) rsel = sema_q[i];
    if (addr == A_STAT)   rsel = status;
    if (addr == A_IRQEN)  rsel = irq_en_q;
    if (addr == A_SUBEND) rsel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q <= '0;
      rdata_q  <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (wr_stb && addr == A_IRQEN) irq_en_q <= wdata;
      rdata_q <= rsel;
      oe_q    <= rd_act;
    end
  end

  assign bus_ad_o = rdata_q;
  assign bus_oe_o = oe_q;

  AST_SEMA_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    sema_wr[0] |=> status[7]); // R4
  AST_SEMA3_BIT1_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == sema_addr(2)) |=> !bus_ad_o[1]); // R9
  AST_IRQ_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    (|(status & irq_en_q)) |=> !irq_n_o); // R8
endmodule

// File: tb/mbus_regif_tb_top.sv
module mbus_regif_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_ad_i = '0;
  logic       ale_i = 1'b0, rd_n_i = 1'b1, wr_n_i = 1'b1, cs_n_i = 1'b1;
  logic [7:0] bus_ad_o;
  logic       bus_oe_o, irq_n_o;
  logic       lock_i = 1'b0, hdr_evt_i = 1'b0, motor_ovf_i = 1'b0, fifo_ovf_i = 1'b0;

  int  n_tests = 0, n_fail = 0;
  bit  quiet = 1'b0, done = 1'b0;

  // behavioural model
  logic [7:0] m_mem [64];
  logic [7:0] m_sema [3];
  bit         m_sf [3];
  bit         m_hdr, m_fifo;
  logic [7:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_regif dut_i (
    .clk(clk), .rst(rst), .bus_ad_i(bus_ad_i), .ale_i(ale_i), .rd_n_i(rd_n_i),
    .wr_n_i(wr_n_i), .cs_n_i(cs_n_i), .bus_ad_o(bus_ad_o), .bus_oe_o(bus_oe_o),
    .lock_i(lock_i), .hdr_evt_i(hdr_evt_i), .motor_ovf_i(motor_ovf_i),
    .fifo_ovf_i(fifo_ovf_i), .irq_n_o(irq_n_o)
  );

  function automatic logic [7:0] m_status();
    return {m_sf[0], m_sf[1], m_sf[2], lock_i, m_hdr, motor_ovf_i, m_fifo, 1'b0};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt pin against the model (R8)
  always @(negedge clk) begin
    if (quiet && !rst)
      check("R8 irq per-clock", {7'd0, irq_n_o}, {7'd0, ~|(m_status() & m_en)});
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_addr(logic [7:0] a);
    bus_ad_i = a; ale_i = 1'b1; wait_n(4);
    ale_i = 1'b0; wait_n(4);
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d, bit use_cs);
    quiet = 1'b0;
    @(negedge clk);
    put_addr(a);
    bus_ad_i = d; cs_n_i = !use_cs; wait_n(2);
    wr_n_i = 1'b0; wait_n(4);
    wr_n_i = 1'b1; wait_n(4);
    cs_n_i = 1'b1; wait_n(4);
    bus_ad_i = '0;
    if (use_cs) begin
      case (a[5:0])
        6'h01, 6'h02, 6'h03: begin
          m_sema[a[1:0]-1] = (a[5:0] == 6'h03) ? (d & 8'hFD) : d;
          m_sf[a[1:0]-1] = 1'b1;
        end
        6'h05: m_en = d;
        default: ;
      endcase
      m_mem[a[5:0]] = d;
    end
    quiet = 1'b1;
  endtask

  function automatic logic [7:0] m_read(logic [5:0] a);
    case (a)
      6'h01, 6'h02, 6'h03: return m_sema[a[1:0]-1];
      6'h04: return m_status();
      6'h05: return m_en;
      6'h06: return 8'h00;
      default: return m_mem[a];
    endcase
  endfunction

  // inject=1 raises a header event in the same cycle as the read's clear
  task automatic bus_read(logic [7:0] a, bit use_cs, bit inject,
                          output logic [7:0] d, output logic oe, output logic [7:0] exp);
    quiet = 1'b0;
    @(negedge clk);
    put_addr(a);
    bus_ad_i = '0; cs_n_i = !use_cs; wait_n(2);
    rd_n_i = 1'b0; wait_n(6);
    exp = m_read(a[5:0]);
    d = bus_ad_o; oe = bus_oe_o;
    rd_n_i = 1'b1;
    if (inject) begin
      wait_n(2); hdr_evt_i = 1'b1;
      wait_n(1); hdr_evt_i = 1'b0;
      wait_n(2);
    end else wait_n(5);
    cs_n_i = 1'b1; wait_n(4);
    if (use_cs) begin
      case (a[5:0])
        6'h01, 6'h02, 6'h03: m_sf[a[1:0]-1] = 1'b0;
        6'h04: m_fifo = 1'b0;
        6'h06: m_hdr = inject;
        default: ;
      endcase
    end
    quiet = 1'b1;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    logic [7:0] d, e; logic oe;
    bus_read(a, 1'b1, 1'b0, d, oe, e);
    check({tag, " data"}, d, e);
    check({tag, " oe"}, {7'd0, oe}, 8'd1);
  endtask

  task automatic pulse(ref logic sig);
    quiet = 1'b0;
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    wait_n(3);
  endtask

  task automatic set_level(ref logic sig, input logic v);
    quiet = 1'b0;
    @(negedge clk); sig = v; wait_n(3);
    quiet = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e; logic oe;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    for (int i = 0; i < 3; i++) begin m_sema[i] = '0; m_sf[i] = 1'b0; end
    m_hdr = 1'b0; m_fifo = 1'b0; m_en = '0;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    check("R10 reset oe", {7'd0, bus_oe_o}, 8'd0);
    check("R10 reset irq_n", {7'd0, irq_n_o}, 8'd1);
    quiet = 1'b1;

    // R1 scratch storage
    bus_write(8'h10, 8'hA5, 1'b1);
    bus_write(8'h2C, 8'h3C, 1'b1);
    rd_chk("R1 scratch 10", 8'h10);
    rd_chk("R1 scratch 2C", 8'h2C);

    // R2 aliasing
    rd_chk("R2 alias 50", 8'h50);
    bus_write(8'hFF, 8'h81, 1'b1);
    rd_chk("R2 alias 3F", 8'h3F);

    // R3 chip select gating
    bus_write(8'h10, 8'h00, 1'b0);
    rd_chk("R3 gated write", 8'h10);
    bus_read(8'h10, 1'b0, 1'b0, d, oe, e);
    check("R3 R10 gated read oe", {7'd0, oe}, 8'd0);

    // R4 semaphore flags, R9 semaphore 3 bit 1
    bus_write(8'h01, 8'h5A, 1'b1);
    rd_chk("R4 status after sema1 write", 8'h04);
    bus_write(8'h43, 8'hFF, 1'b1);
    rd_chk("R4 R2 status after sema3 alias write", 8'h04);
    rd_chk("R4 sema1 read", 8'h01);
    rd_chk("R4 status after sema1 read", 8'h04);
    rd_chk("R9 sema3 read", 8'h03);
    bus_write(8'h02, 8'h66, 1'b1);
    bus_read(8'h02, 1'b0, 1'b0, d, oe, e);
    rd_chk("R3 R4 gated read keeps flag", 8'h04);
    rd_chk("R4 sema2 read", 8'h02);
    rd_chk("R4 status all clear", 8'h04);

    // R5 live bits
    set_level(lock_i, 1'b1);
    set_level(motor_ovf_i, 1'b1);
    rd_chk("R5 status live high", 8'h04);
    set_level(lock_i, 1'b0);
    rd_chk("R5 status lock low", 8'h04);
    set_level(motor_ovf_i, 1'b0);

    // R6 header valid
    pulse(hdr_evt_i); m_hdr = 1'b1; quiet = 1'b1;
    rd_chk("R6 status header set", 8'h04);
    rd_chk("R6 subend read", 8'h06);
    rd_chk("R6 status header cleared", 8'h04);
    pulse(hdr_evt_i); m_hdr = 1'b1; quiet = 1'b1;
    bus_read(8'h06, 1'b1, 1'b1, d, oe, e);
    check("R6 subend data", d, e);
    rd_chk("R6 event wins over clear", 8'h04);

    // R7 FIFO overflow latch
    pulse(fifo_ovf_i); m_fifo = 1'b1; quiet = 1'b1;
    wait_n(20);
    rd_chk("R7 status fifo latched", 8'h04);
    rd_chk("R7 status fifo cleared", 8'h04);

    // R8 interrupt enable
    bus_write(8'h05, 8'h12, 1'b1);
    rd_chk("R8 enable readback", 8'h05);
    set_level(lock_i, 1'b1);
    check("R8 irq low on lock", {7'd0, irq_n_o}, 8'd0);
    set_level(lock_i, 1'b0);
    check("R8 irq high after lock", {7'd0, irq_n_o}, 8'd1);
    pulse(fifo_ovf_i); m_fifo = 1'b1; quiet = 1'b1;
    check("R8 R7 irq low on fifo", {7'd0, irq_n_o}, 8'd0);
    rd_chk("R7 status read clears", 8'h04);
    check("R8 irq released", {7'd0, irq_n_o}, 8'd1);
    bus_write(8'h05, 8'h80, 1'b1);
    bus_write(8'h01, 8'h11, 1'b1);
    check("R8 R4 irq on sema1", {7'd0, irq_n_o}, 8'd0);
    rd_chk("R4 sema1 read 11", 8'h41);
    check("R8 irq after sema1 read", {7'd0, irq_n_o}, 8'd1);

    wait_n(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule